// File: doc/BRIEF.md
# Circular Trace Capture Buffer

The block records a stream of 32-bit trace frames into an on-chip RAM that is addressed as a ring. While capture is enabled, every frame presented on the frame input passes through a one-stage input register and is written at the write pointer, which then advances and wraps at the configured depth. The first wrap raises a sticky Full flag, which tells software that the oldest frame now sits at the write pointer rather than at slot 0.

A trigger pulse arms a post-trigger countdown. Each frame stored after the trigger decrements the trigger counter. When the counter is exhausted, acquisition completes and no further frames are written, so a chosen number of frames after the event is kept. Software reaches all state through a register port with a 7-bit address. Reads return data one cycle after the request. Reading the RAM data register returns the word at the read pointer and moves that pointer on by one.

Top module: `trace_capture_buf`

## Requirements
- R1: A read of address 0 returns the parameter ID_VALUE. A read of any address from 9 to 127 returns 0. Read data appears on reg_rdata_o the cycle after a read request and holds until the next read request.
- R2: Address 1 reads as DEPTH (frames) and address 2 reads as 32 (frame width in bits). Writes to either address have no effect.
- R3: Address 8 is control: bit 0 enables capture and bit 1 selects demultiplexed port mode. Both bits read back. Writing 0 stops capture.
- R4: While capture is enabled and not halted, each frame is stored at the write pointer (address 6). The pointer then advances modulo DEPTH. Software can write this pointer.
- R5: Status (address 3) bit 0, Full, sets when a store moves the write pointer from DEPTH-1 to 0. It stays set until control is written with bit 0 = 1.
- R6: A trigger while capture is enabled sets status bit 1. After that, exactly as many frames as the trigger counter (address 7) holds are stored, and each of them decrements the counter. Once the counter is 0, status bit 2 (acquisition complete) sets and later frames are dropped. A count of 0 completes at once. Writing control with bit 0 = 1 clears bits 1 and 2.
- R7: Each read of address 4 returns the RAM word at the read pointer (address 5), then advances the read pointer modulo DEPTH. Software can write and read the read pointer.
- R8: Status bit 3 is 1 exactly when no frame is pending in the input stage. A frame is taken into that stage one cycle after it is presented.
- R9: Frames that arrive while capture is disabled are not stored and leave the write pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | Frame present this cycle |
| frame_data_i | input | 32 | Frame payload |
| trig_i | input | 1 | Trigger event |
| reg_en_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 7 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |

## Verification
A frame presented at one edge enters the input stage at that edge and reaches the RAM and the write pointer at the next one. Register reads return on the edge after the request. A trigger takes effect for frames that enter the input stage after the edge that samples it. The bench drives every input at a falling edge and lets each frame burst end with one quiet cycle before it issues a register read. Every result is therefore sampled at the falling edge after the edge that produces it, and the counts of pointers, flags and stored words follow directly from how many frames were pushed.

// File: rtl/tcb_pkg.sv
`timescale 1ns/1ps
package tcb_pkg;
  localparam int FRAME_W = 32;

  typedef enum logic [6:0] {
    A_IDENT   = 7'd0,
    A_DEPTH   = 7'd1,
    A_WIDTH   = 7'd2,
    A_STATUS  = 7'd3,
    A_RAMDATA = 7'd4,
    A_RDPTR   = 7'd5,
    A_WRPTR   = 7'd6,
    A_TRIGCNT = 7'd7,
    A_CTRL    = 7'd8
  } reg_addr_e;
endpackage

// File: rtl/tcb_input_stage.sv
`timescale 1ns/1ps
module tcb_input_stage #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         pend_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      data_o <= '0;
    end else begin
      pend_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

  a_r8_pend_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> pend_o);
endmodule

// File: rtl/tcb_ram.sv
`timescale 1ns/1ps
module tcb_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/tcb_acq_ctrl.sv
`timescale 1ns/1ps
module tcb_acq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pend_i,
  input  logic          trig_i,
  input  logic          ctl_wr_i,
  input  logic          wp_wr_i,
  input  logic          tc_wr_i,
  input  logic [31:0]   wdata_i,
  output logic          store_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic          en_o,
  output logic          dmx_o,
  output logic          full_o,
  output logic          trig_seen_o,
  output logic          done_o,
  output logic [31:0]   tcount_o
);
  logic halt, ptr_last, cnt_zero;

  assign cnt_zero = (tcount_o == '0);
  assign halt     = done_o | (trig_seen_o & cnt_zero);
  assign store_o  = pend_i & en_o & ~halt;
  assign ptr_last = (wr_ptr_o == AW'(DEPTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= 1'b0;
      dmx_o       <= 1'b0;
      full_o      <= 1'b0;
      trig_seen_o <= 1'b0;
      done_o      <= 1'b0;
    end else if (ctl_wr_i) begin
      en_o  <= wdata_i[0];
      dmx_o <= wdata_i[1];
      if (wdata_i[0]) begin
        full_o      <= 1'b0;
        trig_seen_o <= 1'b0;
        done_o      <= 1'b0;
      end
    end else begin
      if (en_o && trig_i) trig_seen_o <= 1'b1;
      if (en_o && trig_seen_o && cnt_zero) done_o <= 1'b1;
      if (store_o && ptr_last) full_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      tcount_o <= '0;
    end else begin
      if (wp_wr_i)      wr_ptr_o <= AW'(wdata_i % 32'(DEPTH));
      else if (store_o) wr_ptr_o <= ptr_last ? '0 : wr_ptr_o + 1'b1;
      if (tc_wr_i) tcount_o <= wdata_i;
      else if (store_o && trig_seen_o && !cnt_zero) tcount_o <= tcount_o - 1'b1;
    end
  end

  a_r6_no_store_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !store_o);
  a_r6_done_needs_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(trig_seen_o));
  a_r5_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !ctl_wr_i) |=> full_o);
  a_r4_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(wr_ptr_o) < 32'(DEPTH));
  a_r9_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !wp_wr_i) |=> $stable(wr_ptr_o));
endmodule

// File: rtl/trace_capture_buf.sv
`timescale 1ns/1ps
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter logic [31:0] ID_VALUE = 32'h7CB0_0001,
  localparam int         AW       = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_valid_i,
  input  logic [31:0] frame_data_i,
  input  logic        trig_i,
  input  logic        reg_en_i,
  input  logic        reg_we_i,
  input  logic [6:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  logic               pend;
  logic [FRAME_W-1:0] pend_data, ram_rdata;
  logic               store, en, dmx, full, trig_seen, done;
  logic [AW-1:0]      wr_ptr, rd_ptr;
  logic [31:0]        tcount, rd_mux;
  logic               rd_req, wr_req, rd_last, ram_rd;

  assign rd_req  = reg_en_i & ~reg_we_i;
  assign wr_req  = reg_en_i & reg_we_i;
  assign ram_rd  = rd_req && (reg_addr_i == A_RAMDATA);
  assign rd_last = (rd_ptr == AW'(DEPTH - 1));

  tcb_input_stage #(.W(FRAME_W)) u_in (
    .clk_i, .rst_ni,
    .valid_i (frame_valid_i),
    .data_i  (frame_data_i),
    .pend_o  (pend),
    .data_o  (pend_data)
  );

  tcb_acq_ctrl #(.DEPTH(DEPTH)) u_ctl (
    .clk_i, .rst_ni,
    .pend_i      (pend),
    .trig_i      (trig_i),
    .ctl_wr_i    (wr_req && reg_addr_i == A_CTRL),
    .wp_wr_i     (wr_req && reg_addr_i == A_WRPTR),
    .tc_wr_i     (wr_req && reg_addr_i == A_TRIGCNT),
    .wdata_i     (reg_wdata_i),
    .store_o     (store),
    .wr_ptr_o    (wr_ptr),
    .en_o        (en),
    .dmx_o       (dmx),
    .full_o      (full),
    .trig_seen_o (trig_seen),
    .done_o      (done),
    .tcount_o    (tcount)
  );

  tcb_ram #(.DEPTH(DEPTH), .W(FRAME_W)) u_ram (
    .clk_i,
    .we_i    (store),
    .waddr_i (wr_ptr),
    .wdata_i (pend_data),
    .raddr_i (rd_ptr),
    .rdata_o (ram_rdata)
  );

  always_comb begin
    case (reg_addr_i)
      A_IDENT:   rd_mux = ID_VALUE;
      A_DEPTH:   rd_mux = 32'(DEPTH);
      A_WIDTH:   rd_mux = 32'(FRAME_W);
      A_STATUS:  rd_mux = {28'd0, ~pend, done, trig_seen, full};
      A_RAMDATA: rd_mux = ram_rdata;
      A_RDPTR:   rd_mux = 32'(rd_ptr);
      A_WRPTR:   rd_mux = 32'(wr_ptr);
      A_TRIGCNT: rd_mux = tcount;
      A_CTRL:    rd_mux = {30'd0, dmx, en};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr      <= '0;
      reg_rdata_o <= '0;
    end else begin
      if (wr_req && reg_addr_i == A_RDPTR) rd_ptr <= AW'(reg_wdata_i % 32'(DEPTH));
      else if (ram_rd)                     rd_ptr <= rd_last ? '0 : rd_ptr + 1'b1;
      if (rd_req) reg_rdata_o <= rd_mux;
    end
  end

  a_r7_rd_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd |=> (32'(rd_ptr) == (32'($past(rd_ptr)) + 1) % 32'(DEPTH)));
  a_r1_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && reg_addr_i > 7'd8) |=> (reg_rdata_o == '0));
  a_r1_hold_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(reg_rdata_o));
endmodule

// File: tb/sim_trace_capture_buf.sv
`timescale 1ns/1ps
module sim_trace_capture_buf;
  localparam int          DEPTH = 16;
  localparam logic [31:0] ID    = 32'h7CB0_0001;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fv = 1'b0, trig = 1'b0, ren = 1'b0, rwe = 1'b0;
  logic [31:0] fd = '0, wd = '0, rdata;
  logic [6:0]  ra = '0;
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH), .ID_VALUE(ID)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fv), .frame_data_i(fd),
    .trig_i(trig), .reg_en_i(ren), .reg_we_i(rwe), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rdata));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); ren = 1; rwe = 0; ra = a;
    @(negedge clk); ren = 0; d = rdata;
  endtask

  task automatic rdc(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] v);
    @(negedge clk); ren = 1; rwe = 1; ra = a; wd = v;
    @(negedge clk); ren = 0; rwe = 0;
  endtask

  task automatic push(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fv = 1; fd = base + 32'(i);
    end
    @(negedge clk); fv = 0;
  endtask

  task automatic pulse();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] base, b2;
    base = 32'hA500_0000;
    b2   = 32'h5B00_0000;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // reset state
    rdc("R8 reset status", 7'd3, 32'h8);
    rdc("R4 reset wrptr", 7'd6, 32'd0);
    rdc("R3 reset ctrl", 7'd8, 32'd0);

    // R1 identification and unmapped addresses
    rdc("R1 ident", 7'd0, ID);
    for (int a = 9; a < 128; a += 17) rdc("R1 unmapped", 7'(a), 32'd0);
    rdc("R1 unmapped top", 7'd127, 32'd0);

    // R2 geometry, read only
    rdc("R2 depth", 7'd1, 32'(DEPTH));
    rdc("R2 width", 7'd2, 32'd32);
    wr(7'd1, 32'd5);
    wr(7'd2, 32'd7);
    rdc("R2 depth after write", 7'd1, 32'(DEPTH));
    rdc("R2 width after write", 7'd2, 32'd32);

    // R9 frames ignored while disabled
    push(3, base);
    rdc("R9 wrptr while off", 7'd6, 32'd0);

    // R8 formatter empty follows the input stage
    @(negedge clk); fv = 1; fd = 32'h1;
    rdc("R8 pending", 7'd3, 32'h0);
    fv = 0;
    rdc("R8 drained", 7'd3, 32'h8);
    rdc("R9 wrptr still", 7'd6, 32'd0);

    // R3 control readback
    wr(7'd8, 32'h3);
    rdc("R3 ctrl demux", 7'd8, 32'h3);
    wr(7'd8, 32'h1);
    rdc("R3 ctrl enable", 7'd8, 32'h1);

    // R4 store and advance
    wr(7'd6, 32'd0);
    push(5, base);
    rdc("R4 wrptr", 7'd6, 32'd5);
    rdc("R5 no wrap", 7'd3, 32'h8);

    // R7 RAM data auto-increment
    wr(7'd5, 32'd0);
    for (int i = 0; i < 5; i++) rdc("R7 ram word", 7'd4, base + 32'(i));
    rdc("R7 rdptr", 7'd5, 32'd5);

    // R5 wrap: 19 frames total, oldest at wrptr
    push(14, base + 32'd5);
    rdc("R4 wrptr wrapped", 7'd6, 32'd3);
    rdc("R5 full set", 7'd3, 32'h9);
    wr(7'd5, 32'd3);
    for (int i = 0; i < DEPTH; i++) rdc("R7 oldest first", 7'd4, base + 32'd3 + 32'(i));
    rdc("R7 rdptr wrap", 7'd5, 32'd3);
    rdc("R5 full held", 7'd3, 32'h9);
    wr(7'd8, 32'h1);
    rdc("R5 full cleared", 7'd3, 32'h8);

    // R3 stop
    wr(7'd8, 32'h0);
    push(4, base);
    rdc("R3 stopped wrptr", 7'd6, 32'd3);
    rdc("R3 ctrl zero", 7'd8, 32'd0);

    // R6 post-trigger count
    wr(7'd8, 32'h1);
    wr(7'd6, 32'd0);
    wr(7'd7, 32'd4);
    push(3, b2);
    pulse();
    rdc("R6 triggered", 7'd3, 32'hA);
    rdc("R6 count before", 7'd7, 32'd4);
    push(10, b2 + 32'd3);
    rdc("R6 wrptr stop", 7'd6, 32'd7);
    rdc("R6 complete", 7'd3, 32'hE);
    rdc("R6 count zero", 7'd7, 32'd0);
    wr(7'd5, 32'd0);
    for (int i = 0; i < 7; i++) rdc("R6 kept frame", 7'd4, b2 + 32'(i));
    push(3, base);
    rdc("R6 dropped after", 7'd6, 32'd7);

    // R6 zero count completes at once
    wr(7'd8, 32'h1);
    rdc("R6 flags cleared", 7'd3, 32'h8);
    wr(7'd6, 32'd0);
    wr(7'd7, 32'd0);
    pulse();
    rdc("R6 zero count done", 7'd3, 32'hE);
    push(2, base);
    rdc("R6 zero count no store", 7'd6, 32'd0);

    summary();
  end
endmodule